// File: doc/BRIEF.md
# Bit-Slice Deskew and Latency Leveler

This block sets the timing of one bidirectional data bit slice. The slice has a single phase interpolator. Transmit and receive never run at the same moment on the shared wire, so that one interpolator serves both directions. The block keeps two settings, one for writes and one for reads. Each setting is a fine interpolator code plus a coarse delay counted in unit intervals. A direction input picks which setting is active.

The coarse part is a levelization line. It holds back the parallel data word by a programmable number of bit times, so that slices whose skew exceeds one unit interval reach equal latency. The count is split into two parts. Whole-word steps come from a short word pipeline. The remainder comes from a bit shift across two neighbouring words. With the fine code, the adjustment spans 64 unit intervals. The same mechanism can absorb flight-time differences between command and data lanes, and reference-clock skew between devices.

New settings are written through a configuration port and committed together by a load strobe. The active setting changes only when the lane is idle, which is the bus turnaround gap. It never changes in the middle of a burst.

Top module: `lane_skew_leveler`

## Requirements
- R1: While reset is asserted, `mix_code`, `act_ui` and `dout` are all zero, and both stored settings are zero.
- R2: The four configuration values are captured together at a clock edge where `cfg_load` is 1. At any edge where `cfg_load` is 0, changes on the configuration inputs have no effect on the stored settings.
- R3: At a clock edge where `lane_idle` is 1, `mix_code` takes the read phase code if `dir_rd` is 1, and the write phase code if `dir_rd` is 0. The new value is visible after that edge.
- R4: At an edge where `lane_idle` is 0, `mix_code` and `act_ui` keep their values. This holds whatever `dir_rd` does and even when a load strobe occurs.
- R5: `act_ui` is always taken from the same stored setting, and at the same edge, as `mix_code`.
- R6: `din` is a serial stream, least significant bit first, and its bits are numbered across successive words. The word on `dout` one edge after `din` is sampled equals that stream delayed by `act_ui` bit positions. Positions before reset release read as zero.
- R7: With `act_ui` equal to 0, `dout` equals the `din` word from the previous edge.
- R8: The largest count, 63, delays the stream by exactly 63 bit positions. This is seven whole words plus a 7-bit shift.
- R9: A count that is a multiple of the word width delays by whole words with no bit rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one data word per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Commits all four configuration values at once |
| cfg_wr_ui | input | UI_W (6) | Write-direction coarse delay in bit times |
| cfg_wr_phase | input | PH_W (7) | Write-direction interpolator code |
| cfg_rd_ui | input | UI_W (6) | Read-direction coarse delay in bit times |
| cfg_rd_phase | input | PH_W (7) | Read-direction interpolator code |
| dir_rd | input | 1 | 1 selects the read setting, 0 the write setting |
| lane_idle | input | 1 | 1 while the lane is in a turnaround gap |
| din | input | WORD_W (8) | Parallel data word, bit 0 first in time |
| mix_code | output | PH_W (7) | Code driven to the shared phase interpolator |
| act_ui | output | UI_W (6) | Coarse delay currently applied |
| dout | output | WORD_W (8) | Levelized data word |

## Verification
A setting switch is requested by holding `lane_idle` high across one rising edge. `mix_code` and `act_ui` show the new setting after that edge, so the bench reads them at the following falling edge. A data word is due on `dout` one rising edge after it is applied, shifted by whatever `act_ui` held before that edge. The driver applies each word at a falling edge and queues the expected result, and the monitor compares one nanosecond after the next rising edge. The expected words come from a bit-level history kept in the bench, which stays correct across changes of delay.

// File: rtl/lsl_pkg.sv
package lsl_pkg;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } lane_dir_e;

  // Whole-word pipeline steps contained in a bit-time delay.
  function automatic int unsigned ui_word_steps(input int unsigned ui,
                                                input int unsigned word_w);
    return ui / word_w;
  endfunction

  // Residual bit shift after the whole-word steps are removed.
  function automatic int unsigned ui_bit_shift(input int unsigned ui,
                                               input int unsigned word_w);
    return ui % word_w;
  endfunction

endpackage

// File: rtl/lsl_cfg_bank.sv
module lsl_cfg_bank #(
  parameter int UI_W = 6,
  parameter int PH_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [UI_W-1:0] in_wr_ui,
  input  logic [PH_W-1:0] in_wr_ph,
  input  logic [UI_W-1:0] in_rd_ui,
  input  logic [PH_W-1:0] in_rd_ph,
  output logic [UI_W-1:0] wr_ui,
  output logic [PH_W-1:0] wr_ph,
  output logic [UI_W-1:0] rd_ui,
  output logic [PH_W-1:0] rd_ph
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ui <= '0;
      wr_ph <= '0;
      rd_ui <= '0;
      rd_ph <= '0;
    end else if (load) begin
      wr_ui <= in_wr_ui;
      wr_ph <= in_wr_ph;
      rd_ui <= in_rd_ui;
      rd_ph <= in_rd_ph;
    end
  end

  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(wr_ui) && $stable(wr_ph) && $stable(rd_ui) && $stable(rd_ph)));

endmodule

// File: rtl/lsl_dir_select.sv
module lsl_dir_select
  import lsl_pkg::*;
#(
  parameter int UI_W = 6,
  parameter int PH_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle,
  input  lane_dir_e       dir,
  input  logic [UI_W-1:0] wr_ui,
  input  logic [PH_W-1:0] wr_ph,
  input  logic [UI_W-1:0] rd_ui,
  input  logic [PH_W-1:0] rd_ph,
  output logic [PH_W-1:0] code_q,
  output logic [UI_W-1:0] ui_q
);

  logic            swap_ok;
  logic [PH_W-1:0] code_pick;
  logic [UI_W-1:0] ui_pick;

  assign swap_ok = idle;

  always_comb begin
    if (dir == DIR_READ) begin
      code_pick = rd_ph;
      ui_pick   = rd_ui;
    end else begin
      code_pick = wr_ph;
      ui_pick   = wr_ui;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ui_q   <= '0;
    end else if (swap_ok) begin
      code_q <= code_pick;
      ui_q   <= ui_pick;
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (code_q == '0 && ui_q == '0));

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(code_q) && $stable(ui_q)));

  // R3 R5
  turn_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (code_q == (($past(dir) == DIR_READ) ? $past(rd_ph) : $past(wr_ph))
              && ui_q == (($past(dir) == DIR_READ) ? $past(rd_ui) : $past(wr_ui))));

endmodule

// File: rtl/lsl_level_line.sv
module lsl_level_line
  import lsl_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int UI_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [UI_W-1:0]   ui,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);

  localparam int STAGES = (2 ** UI_W) / WORD_W;

  logic [WORD_W-1:0]   pipe [1:STAGES];
  logic [WORD_W-1:0]   taps [0:STAGES];
  logic [2*WORD_W-1:0] pair;
  int unsigned         step_n;
  int unsigned         shift_n;

  assign taps[0] = din;

  genvar g;
  generate
    for (g = 1; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '0;
        else        pipe[g] <= taps[g-1];
      end
      assign taps[g] = pipe[g];
    end
  endgenerate

  always_comb begin
    step_n  = ui_word_steps(32'(ui), WORD_W);
    shift_n = ui_bit_shift(32'(ui), WORD_W);
    pair    = {taps[step_n], taps[step_n + 1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else        dout <= pair[WORD_W - shift_n +: WORD_W];
  end

  // R7
  zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ui == '0) |=> (dout == $past(din)));

endmodule

// File: rtl/lane_skew_leveler.sv
module lane_skew_leveler
  import lsl_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int UI_W   = 6,
  parameter int PH_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [UI_W-1:0]   cfg_wr_ui,
  input  logic [PH_W-1:0]   cfg_wr_phase,
  input  logic [UI_W-1:0]   cfg_rd_ui,
  input  logic [PH_W-1:0]   cfg_rd_phase,
  input  logic              dir_rd,
  input  logic              lane_idle,
  input  logic [WORD_W-1:0] din,
  output logic [PH_W-1:0]   mix_code,
  output logic [UI_W-1:0]   act_ui,
  output logic [WORD_W-1:0] dout
);

  logic [UI_W-1:0] bank_wr_ui, bank_rd_ui;
  logic [PH_W-1:0] bank_wr_ph, bank_rd_ph;
  lane_dir_e       dir_sel;

  assign dir_sel = dir_rd ? DIR_READ : DIR_WRITE;

  lsl_cfg_bank #(.UI_W(UI_W), .PH_W(PH_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_load),
    .in_wr_ui (cfg_wr_ui),
    .in_wr_ph (cfg_wr_phase),
    .in_rd_ui (cfg_rd_ui),
    .in_rd_ph (cfg_rd_phase),
    .wr_ui    (bank_wr_ui),
    .wr_ph    (bank_wr_ph),
    .rd_ui    (bank_rd_ui),
    .rd_ph    (bank_rd_ph)
  );

  lsl_dir_select #(.UI_W(UI_W), .PH_W(PH_W)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .idle   (lane_idle),
    .dir    (dir_sel),
    .wr_ui  (bank_wr_ui),
    .wr_ph  (bank_wr_ph),
    .rd_ui  (bank_rd_ui),
    .rd_ph  (bank_rd_ph),
    .code_q (mix_code),
    .ui_q   (act_ui)
  );

  lsl_level_line #(.WORD_W(WORD_W), .UI_W(UI_W)) u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .ui    (act_ui),
    .din   (din),
    .dout  (dout)
  );

endmodule

// File: tb/lane_skew_leveler_test.sv
`timescale 1ns/1ps
module lane_skew_leveler_test;

  localparam int WORD_W = 8;
  localparam int UI_W   = 6;
  localparam int PH_W   = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_load = 1'b0;
  logic [UI_W-1:0]   cfg_wr_ui = '0;
  logic [PH_W-1:0]   cfg_wr_phase = '0;
  logic [UI_W-1:0]   cfg_rd_ui = '0;
  logic [PH_W-1:0]   cfg_rd_phase = '0;
  logic              dir_rd = 1'b0;
  logic              lane_idle = 1'b0;
  logic [WORD_W-1:0] din = '0;
  logic [PH_W-1:0]   mix_code;
  logic [UI_W-1:0]   act_ui;
  logic [WORD_W-1:0] dout;

  int checks = 0;
  int errors = 0;
  int cur_d = 0;
  string cur_tag = "R7";
  bit hist[$];
  logic [WORD_W-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  lane_skew_leveler #(.WORD_W(WORD_W), .UI_W(UI_W), .PH_W(PH_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_wr_ui(cfg_wr_ui), .cfg_wr_phase(cfg_wr_phase),
    .cfg_rd_ui(cfg_rd_ui), .cfg_rd_phase(cfg_rd_phase),
    .dir_rd(dir_rd), .lane_idle(lane_idle), .din(din),
    .mix_code(mix_code), .act_ui(act_ui), .dout(dout)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: apply a word at a falling edge, push its levelized expectation.
  task automatic tick(input logic [WORD_W-1:0] w);
    int base;
    logic [WORD_W-1:0] e;
    @(negedge clk);
    din = w;
    base = hist.size();
    for (int j = 0; j < WORD_W; j++) hist.push_back(w[j]);
    for (int j = 0; j < WORD_W; j++) begin
      int idx;
      idx = base + j - cur_d;
      e[j] = (idx < 0) ? 1'b0 : hist[idx];
    end
    exp_q.push_back(e);
    tag_q.push_back(cur_tag);
  endtask

  // Monitor: compare one step after each rising edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [WORD_W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " R6 dout"}, int'(dout), int'(e));
    end
  end

  task automatic stream(input int n);
    for (int i = 0; i < n; i++) tick(WORD_W'($urandom));
  endtask

  // Switch active setting during one idle cycle; bench tracks new delay.
  task automatic turnaround(input logic rd, input int new_d);
    lane_idle = 1'b1;
    dir_rd = rd;
    cur_d = new_d;
    tick(WORD_W'($urandom));
    lane_idle = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 mix_code", int'(mix_code), 0);
    check("R1 act_ui", int'(act_ui), 0);
    check("R1 dout", int'(dout), 0);
    rst_n = 1'b1;

    // R7 zero delay pass-through
    cur_tag = "R7";
    stream(10);

    // R2 load both settings; R4 busy lane keeps active code
    cfg_wr_ui = 6'd0;  cfg_wr_phase = 7'd5;
    cfg_rd_ui = 6'd13; cfg_rd_phase = 7'd40;
    cfg_load = 1'b1; dir_rd = 1'b1;
    tick(WORD_W'($urandom));
    cfg_load = 1'b0;
    check("R4 mix_code held through load", int'(mix_code), 0);
    check("R4 act_ui held through load", int'(act_ui), 0);

    // R3 write selection
    turnaround(1'b0, 0);
    check("R3 write code", int'(mix_code), 5);
    check("R5 write ui", int'(act_ui), 0);
    stream(6);

    // R2 inputs without strobe are ignored
    cfg_rd_ui = 6'd2; cfg_rd_phase = 7'd99;
    stream(2);
    cur_tag = "R6";
    turnaround(1'b1, 13);
    check("R2 read code ignores unloaded input", int'(mix_code), 40);
    check("R5 read ui ignores unloaded input", int'(act_ui), 13);
    stream(12);

    // R4 direction toggles while busy have no effect
    dir_rd = 1'b0;
    stream(4);
    check("R4 mix_code held while busy", int'(mix_code), 40);
    check("R4 act_ui held while busy", int'(act_ui), 13);

    // R8 maximum delay
    cfg_rd_ui = 6'd63; cfg_rd_phase = 7'd127;
    cfg_wr_ui = 6'd16; cfg_wr_phase = 7'd1;
    cfg_load = 1'b1;
    tick(WORD_W'($urandom));
    cfg_load = 1'b0;
    cur_tag = "R8";
    turnaround(1'b1, 63);
    check("R8 max code", int'(mix_code), 127);
    check("R8 max ui", int'(act_ui), 63);
    stream(20);

    // R9 whole-word delay
    cur_tag = "R9";
    turnaround(1'b0, 16);
    check("R9 code", int'(mix_code), 1);
    check("R9 ui", int'(act_ui), 16);
    stream(12);

    // back to zero delay
    cfg_wr_ui = 6'd0; cfg_load = 1'b1;
    tick(WORD_W'($urandom));
    cfg_load = 1'b0;
    cur_tag = "R7";
    turnaround(1'b0, 0);
    stream(6);

    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule